// File: doc/BRIEF.md
# Eight-Port I/O Window Chip-Select Decoder

This block sits on the address bus of a small microcontroller system and picks out an aligned window of eight consecutive I/O locations at the bottom of the upper half of the address space (8000h through 8007h for a 16-bit bus). For an address inside the window, it pulls one of eight active-low chip-select lines low. For any other address, it leaves all eight lines high.

The decode is built from three parts:
- a one-of-eight line decoder with one active-high gate and two active-low gates;
- a wide OR over the address bits between the select field and the top bit, whose result drives one of the low gates;
- the other low gate, which is held asserted.

The top address bit drives the high gate. The three least significant address bits drive the select field.

Two of the selects also drive peripheral strobes. Slot 0 is merged with the processor's active-low write strobe to form a device write strobe. Slot 1 is merged with the active-low read strobe to form a device read strobe. All outputs are registered on the rising clock edge. A synchronous active-high reset drives every output to its inactive (high) level.

Top module: `io_window_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all of `cs_n`, `dev_wr_n` and `dev_rd_n` are 1 after that edge.
- R2: For address 8000h + k (k = 0..7), `cs_n` after the next edge has bit k at 0 and every other bit at 1; bit position k equals the value of `addr[2:0]`.
- R3: Any address with `addr[15]` = 0 (including 0000h) gives `cs_n` = FFh.
- R4: A 1 in any single bit of `addr[14:3]` gives `cs_n` = FFh, even when `addr[15]` = 1 and the low three bits are any value.
- R5: At no time after reset is more than one bit of `cs_n` low.
- R6: `dev_wr_n` is 0 exactly when the address selects slot 0 (8000h) and `wr_n` is 0 at the same edge; otherwise it is 1.
- R7: `dev_rd_n` is 0 exactly when the address selects slot 1 (8001h) and `rd_n` is 0 at the same edge; otherwise it is 1.
- R8: Every output shows the inputs sampled at the most recent rising edge and does not change between edges when the inputs change.
- R9: The `rd_n` and `wr_n` levels have no effect on `cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| cs_n | output | 8 | Registered chip selects for slots 0..7, active low |
| dev_wr_n | output | 1 | Registered peripheral write strobe, active low |
| dev_rd_n | output | 1 | Registered peripheral read strobe, active low |

## Verification
The only state in this block is one register stage, so an internal fault shows up at the ports one edge after the address that triggers it. The faults that can occur are these:
- a wrong gate polarity or a dropped middle bit selects a slot for an address outside the window;
- a swapped select bit lights the wrong slot;
- a crossed strobe pairing moves the write pulse to slot 1.

The stimulus walks a single stray 1 through every middle bit and sweeps all eight slots under all four strobe combinations. It mixes these directed cases with seeded random addresses, so each of these faults appears in the cycle after the stimulus that exposes it.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  // Pair of registered peripheral strobes, both active low.
  typedef struct packed {
    logic wr_n;
    logic rd_n;
  } dev_strobe_t;

  localparam dev_strobe_t STROBE_IDLE = '{wr_n: 1'b1, rd_n: 1'b1};
endpackage

// File: rtl/iodec_mid_or.sv
// OR reduction of the address bits that lie between the select field and
// the top bit; any 1 here means the address is outside the window.
module iodec_mid_or #(
  parameter int MID_W = 12
) (
  input  logic [MID_W-1:0] mid_bits,
  output logic             any_set
);
  // Two-level reduction: groups of four, then the group results.
  localparam int GRP_W = 4;
  localparam int N_GRP = (MID_W + GRP_W - 1) / GRP_W;
  localparam int PAD_W = N_GRP * GRP_W;

  logic [PAD_W-1:0] padded;
  logic [N_GRP-1:0] grp_or;

  always_comb begin
    padded = '0;
    padded[MID_W-1:0] = mid_bits;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_or[g] = |padded[g*GRP_W +: GRP_W];
  end

  assign any_set = |grp_or;
endmodule

// File: rtl/iodec_line_dec.sv
// One-of-N line decoder with one active-high and two active-low gates.
// Outputs are active low; all are high unless every gate is satisfied.
module iodec_line_dec #(
  parameter int SEL_W = 3
) (
  input  logic                   gate_hi,
  input  logic                   gate_lo_a,
  input  logic                   gate_lo_b,
  input  logic [SEL_W-1:0]       sel,
  output logic [(1<<SEL_W)-1:0]  y_n
);
  localparam int N_OUT = 1 << SEL_W;

  logic enabled;
  assign enabled = gate_hi & ~gate_lo_a & ~gate_lo_b;

  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign y_n[i] = ~(enabled && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/iodec_strobe_gate.sv
// Merges two slot selects with the processor strobes (all active low):
// the output is low only when both of its inputs are low.
module iodec_strobe_gate
  import iodec_pkg::*;
(
  input  logic        slot_wr_n,
  input  logic        slot_rd_n,
  input  logic        wr_n,
  input  logic        rd_n,
  output dev_strobe_t strobe
);
  always_comb begin
    strobe.wr_n = slot_wr_n | wr_n;
    strobe.rd_n = slot_rd_n | rd_n;
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iodec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rd_n,
  input  logic                   wr_n,
  output logic [(1<<SEL_W)-1:0]  cs_n,
  output logic                   dev_wr_n,
  output logic                   dev_rd_n
);
  localparam int NUM_CS = 1 << SEL_W;
  localparam int MID_W  = ADDR_W - 1 - SEL_W;

  logic              mid_any;
  logic [NUM_CS-1:0] cs_n_d;
  dev_strobe_t       strobe_d;
  dev_strobe_t       strobe_q;

  iodec_mid_or #(.MID_W(MID_W)) u_mid_or (
    .mid_bits (addr[ADDR_W-2:SEL_W]),
    .any_set  (mid_any)
  );

  iodec_line_dec #(.SEL_W(SEL_W)) u_line_dec (
    .gate_hi   (addr[ADDR_W-1]),
    .gate_lo_a (mid_any),
    .gate_lo_b (1'b0),
    .sel       (addr[SEL_W-1:0]),
    .y_n       (cs_n_d)
  );

  iodec_strobe_gate u_strobe_gate (
    .slot_wr_n (cs_n_d[0]),
    .slot_rd_n (cs_n_d[1]),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .strobe    (strobe_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= '1;
      strobe_q <= STROBE_IDLE;
    end else begin
      cs_n     <= cs_n_d;
      strobe_q <= strobe_d;
    end
  end

  assign dev_wr_n = strobe_q.wr_n;
  assign dev_rd_n = strobe_q.rd_n;

  // R5: never two selects low together.
  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  // R3: top bit clear leaves every select high at the next edge.
  assert_nohi_R3: assert property (@(posedge clk) disable iff (rst)
    !addr[ADDR_W-1] |=> (&cs_n));

  // R4: a stray middle bit leaves every select high at the next edge.
  assert_stray_R4: assert property (@(posedge clk) disable iff (rst)
    (|addr[ADDR_W-2:SEL_W]) |=> (&cs_n));

  // R2: an in-window address lights exactly the slot named by the low bits.
  assert_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1] && !(|addr[ADDR_W-2:SEL_W]))
      |=> ((~cs_n) == (NUM_CS'(1) << $past(addr[SEL_W-1:0]))));

  // R6: a device write pulse needs slot 0 and a low write strobe.
  assert_wr_R6: assert property (@(posedge clk) disable iff (rst)
    !dev_wr_n |-> (!cs_n[0] && !$past(wr_n)));

  // R7: a device read pulse needs slot 1 and a low read strobe.
  assert_rd_R7: assert property (@(posedge clk) disable iff (rst)
    !dev_rd_n |-> (!cs_n[1] && !$past(rd_n)));
endmodule

// File: tb/io_window_decoder_bench.sv
`timescale 1ns/1ps
module io_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  cs_n;
  logic        dev_wr_n;
  logic        dev_rd_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  io_window_decoder u_io_window_decoder (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cs_n     (cs_n),
    .dev_wr_n (dev_wr_n),
    .dev_rd_n (dev_rd_n)
  );

  function automatic logic [7:0] exp_cs(logic [15:0] a);
    if (a[15] && a[14:3] == 12'h000) return ~(8'h01 << a[2:0]);
    return 8'hFF;
  endfunction

  function automatic logic exp_wr(logic [15:0] a, logic w);
    return !(a == 16'h8000 && !w);
  endfunction

  function automatic logic exp_rd(logic [15:0] a, logic r);
    return !(a == 16'h8001 && !r);
  endfunction

  task automatic check_val(string req, logic [7:0] got, logic [7:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, expv);
    end
  endtask

  task automatic drive(logic [15:0] a, logic r, logic w);
    @(negedge clk);
    addr = a; rd_n = r; wr_n = w;
    @(posedge clk);
    #1;
  endtask

  task automatic apply_check(string req, logic [15:0] a, logic r, logic w);
    drive(a, r, w);
    check_val(req, cs_n, exp_cs(a));
    check_val("R6", {7'd0, dev_wr_n}, {7'd0, exp_wr(a, w)});
    check_val("R7", {7'd0, dev_rd_n}, {7'd0, exp_rd(a, r)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state with an in-window write pending
    addr = 16'h8000; wr_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_val("R1", cs_n, 8'hFF);
    check_val("R1", {6'd0, dev_wr_n, dev_rd_n}, 8'h03);
    @(negedge clk); rst = 1'b0; wr_n = 1'b1;

    // R2: every slot, strobes idle
    for (int k = 0; k < 8; k++) apply_check("R2", 16'h8000 + 16'(k), 1'b1, 1'b1);

    // R9: strobes must not move the selects
    for (int k = 0; k < 8; k++)
      for (int s = 0; s < 4; s++)
        apply_check("R9", 16'h8000 + 16'(k), s[0], s[1]);

    // R6 / R7: directed strobe gating
    apply_check("R6", 16'h8000, 1'b1, 1'b0);
    check_val("R6", {7'd0, dev_wr_n}, 8'h00);
    apply_check("R7", 16'h8001, 1'b0, 1'b1);
    check_val("R7", {7'd0, dev_rd_n}, 8'h00);
    apply_check("R6", 16'h8001, 1'b1, 1'b0);
    apply_check("R7", 16'h8000, 1'b0, 1'b1);

    // R3: top bit clear
    apply_check("R3", 16'h0000, 1'b0, 1'b0);
    apply_check("R3", 16'h0001, 1'b0, 1'b0);
    apply_check("R3", 16'h7FFF, 1'b0, 1'b0);

    // R4: walk one stray bit through the middle field
    for (int b = 3; b <= 14; b++)
      apply_check("R4", 16'h8000 | (16'h0001 << b), 1'b0, 1'b0);
    apply_check("R4", 16'hFFFF, 1'b0, 1'b0);

    // R8: outputs hold between edges
    apply_check("R8", 16'h8000, 1'b1, 1'b1);
    @(negedge clk); addr = 16'h8003;
    #1;
    check_val("R8", cs_n, 8'hFE);
    @(posedge clk); #1;
    check_val("R8", cs_n, 8'hF7);

    // Seeded random mix
    for (int n = 0; n < 400; n++) begin
      int mode;
      logic [15:0] a;
      mode = $urandom % 4;
      case (mode)
        0: a = 16'h8000 | 16'($urandom % 8);
        1: a = 16'h8000 | (16'h0001 << (3 + ($urandom % 12))) | 16'($urandom % 8);
        2: a = 16'($urandom) & 16'h7FFF;
        default: a = 16'($urandom);
      endcase
      case (mode)
        0: apply_check("R2", a, 1'($urandom), 1'($urandom));
        1: apply_check("R4", a, 1'($urandom), 1'($urandom));
        2: apply_check("R3", a, 1'($urandom), 1'($urandom));
        default: apply_check("R5", a, 1'($urandom), 1'($urandom));
      endcase
    end

    // R1: reset mid-run clears an active select and strobe
    drive(16'h8000, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check_val("R1", cs_n, 8'hFF);
    check_val("R1", {7'd0, dev_wr_n}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule